// File: doc/BRIEF.md
# Read Completion Ordering Arbiter

This block decides the next item that travels toward the primary side when two sources share that path: a queue of posted writes and a queue of delayed-read completions. Each incoming write is stamped with a running sequence number. Each incoming completion records how many writes had been accepted when it arrived. A completion may not leave while a write that is older than it is still queued, unless it qualifies for relaxed ordering.

A completion qualifies for relaxed ordering when four conditions hold. It is headed for the primary side. It is not the first completion of its read. The first completion carrying the same tag has already been issued. Relaxed ordering is also enabled for the completion's mode: a configuration bit enables it for conventional-mode requests, and the per-request attribute enables it for extended-mode requests. The chosen queue head is offered on a single valid/ready output. It stays fixed until it is accepted.

Top module: `cpl_order_arb`

## Requirements
- R1: After reset, `out_valid` is 0 and both `wr_in_ready` and `cp_in_ready` are 1.
- R2: With relaxed ordering not permitted, a completion is issued only after every write accepted before it has been issued.
- R3: A write and a completion accepted in the same cycle count as write-first. The completion waits for that write.
- R4: In conventional mode (`cp_in_ext_mode`=0) with `cfg_relax_en`=1, the first completion of a read (`cp_in_first`=1) still waits behind older writes. A later completion with the same tag, arriving once the first has been issued, goes out ahead of pending older writes.
- R5: In extended mode (`cp_in_ext_mode`=1), `cp_in_ro_attr` alone selects relaxed ordering and `cfg_relax_en` has no effect.
- R6: A completion with `cp_in_to_primary`=0 is always strictly ordered behind older writes, whatever the enable and attribute say.
- R7: When the completion head may issue, it is selected ahead of the write head. Otherwise the write head is selected.
- R8: Writes leave in acceptance order, and completions leave in acceptance order.
- R9: While `out_valid`=1 and `out_ready`=0, `out_is_cpl`, `out_data` and `out_tag` do not change, even if another entry becomes eligible.
- R10: When a queue holds its full depth, its ready output is 0, and an offered item is not accepted. The ready output returns to 1 once an entry has left the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_relax_en | input | 1 | Relaxed-ordering enable for conventional-mode requests |
| wr_in_valid | input | 1 | Posted write offered |
| wr_in_ready | output | 1 | Write queue can accept |
| wr_in_data | input | DATA_W | Write payload |
| cp_in_valid | input | 1 | Completion offered |
| cp_in_ready | output | 1 | Completion queue can accept |
| cp_in_data | input | DATA_W | Completion payload |
| cp_in_tag | input | TAG_W | Read transaction tag |
| cp_in_first | input | 1 | 1 = first completion of its read |
| cp_in_ext_mode | input | 1 | 1 = request was issued in extended mode |
| cp_in_ro_attr | input | 1 | Per-request relaxed-ordering attribute |
| cp_in_to_primary | input | 1 | 1 = completion is presented on the primary side |
| out_valid | output | 1 | Selected entry is valid |
| out_ready | input | 1 | Consumer accepts the entry |
| out_is_cpl | output | 1 | 1 = completion, 0 = write |
| out_data | output | DATA_W | Payload of the selected entry |
| out_tag | output | TAG_W | Tag of a selected completion, 0 for a write |

## Verification
Two events can land in the same cycle. The first is a write and a completion being accepted together. The second is a completion gaining the right to pass while a write is already on offer and stalled. The bench drives both valid inputs in one cycle and expects the write first in all strictly ordered cases. It then holds `out_ready` low while a tag-qualified later completion arrives behind a presented write, and requires the write to stay on the output unchanged until it is accepted. Only then may the completion go out.

// File: rtl/cpl_order_pkg.sv
package cpl_order_pkg;
    // Source of the entry presented on the output
    typedef enum logic {
        SRC_WRITE = 1'b0,
        SRC_CPL   = 1'b1
    } src_e;
endpackage

// File: rtl/cpl_order_fifo.sv
module cpl_order_fifo #(
    parameter int W = 8,
    parameter int D = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (D > 1) ? $clog2(D) : 1;
    localparam int CW = $clog2(D + 1);

    typedef struct packed {
        logic [D-1:0][W-1:0] mem;
        logic [AW-1:0]       rd;
        logic [AW-1:0]       wr;
        logic [CW-1:0]       cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(D - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.mem[s_q.wr] = din;
            s_d.wr          = bump(s_q.wr);
        end
        if (pop) begin
            s_d.rd = bump(s_q.rd);
        end
        s_d.cnt = s_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout  = s_q.mem[s_q.rd];
    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CW'(D));

    // R10: never written past its depth
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (s_q.cnt != CW'(D)));
    // R8: never popped while empty
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (s_q.cnt != '0));
endmodule

// File: rtl/cpl_order_gate.sv
module cpl_order_gate #(
    parameter int TAG_W = 3,
    parameter int SEQ_W = 4
) (
    input  logic                 cfg_relax_en,
    input  logic                 wr_empty,
    input  logic [SEQ_W-1:0]     wr_head_seq,
    input  logic                 cp_empty,
    input  logic [SEQ_W-1:0]     cp_wseq,
    input  logic [TAG_W-1:0]     cp_tag,
    input  logic                 cp_first,
    input  logic                 cp_ext,
    input  logic                 cp_ro,
    input  logic                 cp_prim,
    input  logic [(1<<TAG_W)-1:0] seen,
    output logic                 older_wr,
    output logic                 pass_ok,
    output logic                 cp_elig
);
    logic [SEQ_W-1:0] age_gap;
    logic             mode_relax;

    always_comb begin
        // write head is older when its sequence lies strictly behind the stamp
        age_gap    = cp_wseq - wr_head_seq;
        older_wr   = !wr_empty && (age_gap != '0) && !age_gap[SEQ_W-1];
        mode_relax = cp_ext ? cp_ro : cfg_relax_en;
        pass_ok    = cp_prim && mode_relax && !cp_first && seen[cp_tag];
        cp_elig    = !cp_empty && (!older_wr || pass_ok);
    end
endmodule

// File: rtl/cpl_order_arb.sv
module cpl_order_arb
    import cpl_order_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int TAG_W    = 3,
    parameter int WR_DEPTH = 4,
    parameter int CP_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_relax_en,
    input  logic              wr_in_valid,
    output logic              wr_in_ready,
    input  logic [DATA_W-1:0] wr_in_data,
    input  logic              cp_in_valid,
    output logic              cp_in_ready,
    input  logic [DATA_W-1:0] cp_in_data,
    input  logic [TAG_W-1:0]  cp_in_tag,
    input  logic              cp_in_first,
    input  logic              cp_in_ext_mode,
    input  logic              cp_in_ro_attr,
    input  logic              cp_in_to_primary,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_is_cpl,
    output logic [DATA_W-1:0] out_data,
    output logic [TAG_W-1:0]  out_tag
);
    localparam int SEQ_W = $clog2(WR_DEPTH) + 2;
    localparam int NTAGS = 1 << TAG_W;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [SEQ_W-1:0]  seq;
    } wr_ent_t;

    typedef struct packed {
        logic              prim;
        logic              ext;
        logic              ro;
        logic              first;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
        logic [SEQ_W-1:0]  wseq;
    } cp_ent_t;

    typedef struct packed {
        logic             hold;
        src_e             sel;
        logic [NTAGS-1:0] seen;
        logic [SEQ_W-1:0] wr_seq;
    } arb_st_t;

    localparam int WR_W = $bits(wr_ent_t);
    localparam int CP_W = $bits(cp_ent_t);

    arb_st_t st_d, st_q;

    logic            wr_full, wr_empty, cp_full, cp_empty;
    logic            wr_push, cp_push, wr_pop, cp_pop;
    logic [WR_W-1:0] wr_dout;
    logic [CP_W-1:0] cp_dout;
    wr_ent_t         wr_new, wr_head;
    cp_ent_t         cp_new, cp_head;
    logic            older_wr, pass_ok, cp_elig;
    src_e            sel;
    logic            fire;

    assign wr_in_ready = !wr_full;
    assign cp_in_ready = !cp_full;
    assign wr_push     = wr_in_valid && !wr_full;
    assign cp_push     = cp_in_valid && !cp_full;

    always_comb begin
        wr_new.data = wr_in_data;
        wr_new.seq  = st_q.wr_seq;
        // stamp counts a same-cycle write as already ahead
        cp_new.wseq  = st_q.wr_seq + SEQ_W'(wr_push);
        cp_new.data  = cp_in_data;
        cp_new.tag   = cp_in_tag;
        cp_new.first = cp_in_first;
        cp_new.ro    = cp_in_ro_attr;
        cp_new.ext   = cp_in_ext_mode;
        cp_new.prim  = cp_in_to_primary;
        wr_head      = wr_ent_t'(wr_dout);
        cp_head      = cp_ent_t'(cp_dout);
    end

    cpl_order_fifo #(.W(WR_W), .D(WR_DEPTH)) u_wr_q (
        .clk(clk), .rst_n(rst_n), .push(wr_push), .din(wr_new),
        .pop(wr_pop), .dout(wr_dout), .empty(wr_empty), .full(wr_full));

    cpl_order_fifo #(.W(CP_W), .D(CP_DEPTH)) u_cp_q (
        .clk(clk), .rst_n(rst_n), .push(cp_push), .din(cp_new),
        .pop(cp_pop), .dout(cp_dout), .empty(cp_empty), .full(cp_full));

    cpl_order_gate #(.TAG_W(TAG_W), .SEQ_W(SEQ_W)) u_gate (
        .cfg_relax_en(cfg_relax_en), .wr_empty(wr_empty), .wr_head_seq(wr_head.seq),
        .cp_empty(cp_empty), .cp_wseq(cp_head.wseq), .cp_tag(cp_head.tag),
        .cp_first(cp_head.first), .cp_ext(cp_head.ext), .cp_ro(cp_head.ro),
        .cp_prim(cp_head.prim), .seen(st_q.seen),
        .older_wr(older_wr), .pass_ok(pass_ok), .cp_elig(cp_elig));

    always_comb begin
        st_d = st_q;
        if (st_q.hold) sel = st_q.sel;
        else           sel = cp_elig ? SRC_CPL : SRC_WRITE;
        out_valid  = st_q.hold || cp_elig || !wr_empty;
        out_is_cpl = (sel == SRC_CPL);
        out_data   = out_is_cpl ? cp_head.data : wr_head.data;
        out_tag    = out_is_cpl ? cp_head.tag : '0;
        fire       = out_valid && out_ready;
        wr_pop     = fire && (sel == SRC_WRITE);
        cp_pop     = fire && (sel == SRC_CPL);

        st_d.hold   = out_valid && !out_ready;
        st_d.sel    = sel;
        st_d.wr_seq = st_q.wr_seq + SEQ_W'(wr_push);
        if (cp_pop && cp_head.first) st_d.seen[cp_head.tag] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: presented entry frozen while stalled
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_is_cpl)
                                       && $stable(out_data) && $stable(out_tag)));
    // R2/R6: a completion behind older writes leaves only when passing is allowed
    p_strict_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_cpl && !pass_ok) |-> !older_wr);
    // R4: a first completion never overtakes an older write
    p_first_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_cpl && older_wr) |-> !cp_head.first);
    // R7: a write is not chosen freshly while the completion head may issue
    p_cpl_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_cpl && !st_q.hold) |-> !cp_elig);
endmodule

// File: tb/cpl_order_arb_tb_top.sv
module cpl_order_arb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_relax_en = 1'b0;
    logic        wr_in_valid = 1'b0;
    logic        wr_in_ready;
    logic [15:0] wr_in_data = '0;
    logic        cp_in_valid = 1'b0;
    logic        cp_in_ready;
    logic [15:0] cp_in_data = '0;
    logic [2:0]  cp_in_tag = '0;
    logic        cp_in_first = 1'b0;
    logic        cp_in_ext_mode = 1'b0;
    logic        cp_in_ro_attr = 1'b0;
    logic        cp_in_to_primary = 1'b1;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_is_cpl;
    logic [15:0] out_data;
    logic [2:0]  out_tag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [16:0] expq[$];
    string cur_req = "R1";

    always #5 clk = ~clk;

    cpl_order_arb dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_relax_en(cfg_relax_en),
        .wr_in_valid(wr_in_valid), .wr_in_ready(wr_in_ready), .wr_in_data(wr_in_data),
        .cp_in_valid(cp_in_valid), .cp_in_ready(cp_in_ready), .cp_in_data(cp_in_data),
        .cp_in_tag(cp_in_tag), .cp_in_first(cp_in_first), .cp_in_ext_mode(cp_in_ext_mode),
        .cp_in_ro_attr(cp_in_ro_attr), .cp_in_to_primary(cp_in_to_primary),
        .out_valid(out_valid), .out_ready(out_ready), .out_is_cpl(out_is_cpl),
        .out_data(out_data), .out_tag(out_tag));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, expv);
        end
    endtask

    // scoreboard monitor: compares every accepted output against the queue
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL %s actual %0h expected none", cur_req, {out_is_cpl, out_data});
            end else begin
                logic [16:0] e;
                e = expq.pop_front();
                if ({out_is_cpl, out_data} !== e) begin
                    errors++;
                    $display("FAIL %s actual %0h expected %0h", cur_req, {out_is_cpl, out_data}, e);
                end
            end
        end
    end

    task automatic expect_out(input logic kind, input logic [15:0] d);
        expq.push_back({kind, d});
    endtask

    task automatic set_cp(input logic [15:0] d, input logic [2:0] tag, input logic first,
                          input logic ext, input logic ro, input logic prim);
        cp_in_valid = 1'b1; cp_in_data = d; cp_in_tag = tag; cp_in_first = first;
        cp_in_ext_mode = ext; cp_in_ro_attr = ro; cp_in_to_primary = prim;
    endtask

    task automatic push_wr(input logic [15:0] d);
        wr_in_valid = 1'b1; wr_in_data = d;
        @(posedge clk); #2;
        wr_in_valid = 1'b0;
    endtask

    task automatic push_cp(input logic [15:0] d, input logic [2:0] tag, input logic first,
                           input logic ext, input logic ro, input logic prim);
        set_cp(d, tag, first, ext, ro, prim);
        @(posedge clk); #2;
        cp_in_valid = 1'b0;
    endtask

    task automatic push_both(input logic [15:0] wd, input logic [15:0] cd, input logic [2:0] tag,
                             input logic first, input logic ext, input logic ro, input logic prim);
        wr_in_valid = 1'b1; wr_in_data = wd;
        set_cp(cd, tag, first, ext, ro, prim);
        @(posedge clk); #2;
        wr_in_valid = 1'b0; cp_in_valid = 1'b0;
    endtask

    task automatic drain();
        out_ready = 1'b1;
        for (int i = 0; i < 100 && expq.size() != 0; i++) @(negedge clk);
        @(posedge clk); #2;
        out_ready = 1'b0;
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL %s actual %0d items left expected 0", cur_req, expq.size());
            expq.delete();
        end
        @(negedge clk);
        check({cur_req, " idle"}, {31'd0, out_valid}, 32'd0);
        @(posedge clk); #2;
    endtask

    // W1+C(first) together, then W2, then C(later, same tag)
    task automatic pattern(input logic [7:0] b, input logic [2:0] tag,
                           input logic ext, input logic ro, input logic prim, input bit relaxed);
        push_both({8'hA0, b}, {8'hC0, b}, tag, 1'b1, ext, ro, prim);
        push_wr({8'hA1, b});
        push_cp({8'hC1, b}, tag, 1'b0, ext, ro, prim);
        expect_out(1'b0, {8'hA0, b});          // R3: same-cycle write goes first
        expect_out(1'b1, {8'hC0, b});          // R7: free completion beats younger write
        if (relaxed) begin
            expect_out(1'b1, {8'hC1, b});      // later completion passes
            expect_out(1'b0, {8'hA1, b});
        end else begin
            expect_out(1'b0, {8'hA1, b});      // strict wait
            expect_out(1'b1, {8'hC1, b});
        end
        drain();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 wr_in_ready", {31'd0, wr_in_ready}, 32'd1);
        check("R1 cp_in_ready", {31'd0, cp_in_ready}, 32'd1);
        @(posedge clk); #2;

        cur_req = "R2_R3_R8 strict conventional";
        cfg_relax_en = 1'b0;
        pattern(8'h01, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0);

        cur_req = "R4_R7 relaxed conventional";
        cfg_relax_en = 1'b1;
        pattern(8'h02, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1);

        cur_req = "R5 extended attr=0 cfg=1";
        cfg_relax_en = 1'b1;
        pattern(8'h03, 3'd5, 1'b1, 1'b0, 1'b1, 1'b0);

        cur_req = "R5 extended attr=1 cfg=0";
        cfg_relax_en = 1'b0;
        pattern(8'h04, 3'd6, 1'b1, 1'b1, 1'b1, 1'b1);

        cur_req = "R6 non-primary";
        cfg_relax_en = 1'b1;
        pattern(8'h05, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0);

        cur_req = "R9 hold while stalled";
        cfg_relax_en = 1'b1;
        push_wr(16'hA006);
        push_cp(16'hC006, 3'd4, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9 kind", {31'd0, out_is_cpl}, 32'd0);
            check("R9 data", {16'd0, out_data}, 32'h0000A006);
        end
        @(posedge clk); #2;
        expect_out(1'b0, 16'hA006);
        expect_out(1'b1, 16'hC006);
        drain();

        cur_req = "R10_R8 full write queue";
        for (int i = 0; i < 4; i++) push_wr(16'hA100 + 16'(i));
        @(negedge clk);
        check("R10 wr_in_ready full", {31'd0, wr_in_ready}, 32'd0);
        @(posedge clk); #2;
        push_wr(16'hA1FF);
        for (int i = 0; i < 4; i++) expect_out(1'b0, 16'hA100 + 16'(i));
        drain();
        check("R10 wr_in_ready after drain", {31'd0, wr_in_ready}, 32'd1);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog %s actual hung expected done", cur_req);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule